// File: doc/BRIEF.md
# Compare-and-Branch Resolution Unit

This unit decides conditional branches for a processor whose compare instruction does not produce flags. Instead, a compare stores its two 32-bit source values in a pair of operand latches. A later conditional branch names a 4-bit condition code and carries a 10-bit signed halfword offset. It also supplies its own address. The unit evaluates the condition against the stored operands and registers three results: the taken decision, the next PC, and a flag for an undefined condition code.

A branch may be presented in the same cycle as the compare that feeds it. In that case a bypass makes the new operands visible to the evaluation, so that back-to-back compare/branch pairs need no stall. Results appear one clock after the branch is presented and are qualified by a valid strobe.

Top module: `cmp_branch_unit`

## Requirements
- R1: After reset, res_valid_o, res_taken_o, res_illegal_o and res_next_pc_o are 0, and both operand latches hold 0, so an equal test (code 0) taken right after reset is taken.
- R2: A compare (cmp_valid_i high) stores cmp_a_i as operand a and cmp_b_i as operand b. The stored values persist until the next compare, and later branches evaluate against them.
- R3: A branch presented in the same cycle as a compare evaluates against that compare's operands, not the previously stored ones.
- R4: Code 0 is taken when a equals b, and code 1 is taken when a differs from b.
- R5: The signed tests, with a and b read as two's complement, are: code 2 taken when a < b, code 3 when a > b, code 6 when a >= b, and code 7 when a <= b.
- R6: The unsigned tests are: code 4 taken when a < b, code 5 when a > b, code 8 when a >= b, and code 9 when a <= b.
- R7: A taken branch yields res_next_pc_o = br_pc_i + 2 + (the 10-bit offset sign-extended, then shifted left by one).
- R8: A legal branch that is not taken yields res_next_pc_o = br_pc_i + 2.
- R9: Codes 10 to 15 set res_illegal_o to 1 and res_taken_o to 0, and leave res_next_pc_o equal to br_pc_i.
- R10: res_valid_o is high in exactly the cycle after a cycle with br_valid_i high, and low otherwise.
- R11: A compare without a branch leaves res_taken_o, res_illegal_o and res_next_pc_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmp_valid_i | input | 1 | Compare instruction present |
| cmp_a_i | input | 32 | First compare source |
| cmp_b_i | input | 32 | Second compare source |
| br_valid_i | input | 1 | Conditional branch present |
| br_cond_i | input | 4 | Condition code |
| br_offset_i | input | 10 | Signed halfword offset field |
| br_pc_i | input | 32 | Address of the branch |
| res_valid_o | output | 1 | Result strobe, one cycle after the branch |
| res_taken_o | output | 1 | Branch taken |
| res_next_pc_o | output | 32 | Next PC |
| res_illegal_o | output | 1 | Undefined condition code |

## Verification
The compare capture and the branch evaluation can fall in the same cycle, and that is where the bypass must pick the incoming operands over the stored ones. The bench provokes this both in directed cases and in random cycles that raise cmp_valid_i and br_valid_i together with operands that differ from the stored pair. Its reference model updates the operand pair before it computes the expected decision, so a design that reads the stale latch produces a mismatching taken bit or next PC.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int unsigned XLEN = 32;

  typedef enum logic [3:0] {
    CC_EQ  = 4'd0,
    CC_NE  = 4'd1,
    CC_LT  = 4'd2,
    CC_GT  = 4'd3,
    CC_LTU = 4'd4,
    CC_GTU = 4'd5,
    CC_GE  = 4'd6,
    CC_LE  = 4'd7,
    CC_GEU = 4'd8,
    CC_LEU = 4'd9
  } cond_e;

  typedef struct packed {
    logic            taken;
    logic            illegal;
    logic [XLEN-1:0] next_pc;
  } br_res_t;
endpackage

// File: rtl/cbr_operand_latch.sv
module cbr_operand_latch #(
  parameter int unsigned WIDTH     = 32,
  parameter bit          BYPASS_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_valid_i,
  input  logic [WIDTH-1:0] cmp_a_i,
  input  logic [WIDTH-1:0] cmp_b_i,
  output logic [WIDTH-1:0] op_a_o,
  output logic [WIDTH-1:0] op_b_o
);
  logic [WIDTH-1:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (cmp_valid_i) begin
      a_q <= cmp_a_i;
      b_q <= cmp_b_i;
    end
  end

  generate
    if (BYPASS_EN) begin : g_bypass
      assign op_a_o = cmp_valid_i ? cmp_a_i : a_q;
      assign op_b_o = cmp_valid_i ? cmp_b_i : b_q;
    end else begin : g_direct
      assign op_a_o = a_q;
      assign op_b_o = b_q;
    end
  endgenerate

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_valid_i |=> (a_q == $past(cmp_a_i)) && (b_q == $past(cmp_b_i)));
  a_r2_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_valid_i |=> $stable(a_q) && $stable(b_q));
endmodule

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] op_a_i,
  input  logic [WIDTH-1:0] op_b_i,
  input  logic [3:0]       cond_i,
  output logic             taken_o,
  output logic             legal_o
);
  logic eq, lt_s, gt_s, lt_u, gt_u;

  assign eq   = (op_a_i == op_b_i);
  assign lt_s = ($signed(op_a_i) < $signed(op_b_i));
  assign gt_s = ($signed(op_a_i) > $signed(op_b_i));
  assign lt_u = (op_a_i < op_b_i);
  assign gt_u = (op_a_i > op_b_i);

  always_comb begin
    legal_o = 1'b1;
    taken_o = 1'b0;
    case (cond_e'(cond_i))
      CC_EQ:   taken_o = eq;
      CC_NE:   taken_o = !eq;
      CC_LT:   taken_o = lt_s;
      CC_GT:   taken_o = gt_s;
      CC_GE:   taken_o = !lt_s;
      CC_LE:   taken_o = !gt_s;
      CC_LTU:  taken_o = lt_u;
      CC_GTU:  taken_o = gt_u;
      CC_GEU:  taken_o = !lt_u;
      CC_LEU:  taken_o = !gt_u;
      default: legal_o = 1'b0;
    endcase
  end

  // exactly one ordering holds per domain
  a_r5_signed_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({lt_s, gt_s, eq}) == 1);
  a_r6_unsigned_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({lt_u, gt_u, eq}) == 1);
  a_r9_illegal_never_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !legal_o |-> !taken_o);
endmodule

// File: rtl/cbr_target_gen.sv
module cbr_target_gen #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned OFF_W  = 10,
  parameter int unsigned STEP   = 2
) (
  input  logic [WIDTH-1:0] pc_i,
  input  logic [OFF_W-1:0] offset_i,
  output logic [WIDTH-1:0] seq_pc_o,
  output logic [WIDTH-1:0] tgt_pc_o
);
  localparam int unsigned EXT_W = WIDTH - OFF_W;

  logic [WIDTH-1:0] off_ext, off_scaled;

  assign off_ext    = {{EXT_W{offset_i[OFF_W-1]}}, offset_i};
  assign off_scaled = off_ext << 1;
  assign seq_pc_o   = pc_i + WIDTH'(STEP);
  assign tgt_pc_o   = seq_pc_o + off_scaled;
endmodule

// File: rtl/cmp_branch_unit.sv
module cmp_branch_unit
  import cbr_pkg::*;
#(
  parameter int unsigned WIDTH     = XLEN,
  parameter int unsigned OFF_W     = 10,
  parameter int unsigned COND_W    = 4,
  parameter bit          BYPASS_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmp_valid_i,
  input  logic [WIDTH-1:0]  cmp_a_i,
  input  logic [WIDTH-1:0]  cmp_b_i,
  input  logic              br_valid_i,
  input  logic [COND_W-1:0] br_cond_i,
  input  logic [OFF_W-1:0]  br_offset_i,
  input  logic [WIDTH-1:0]  br_pc_i,
  output logic              res_valid_o,
  output logic              res_taken_o,
  output logic [WIDTH-1:0]  res_next_pc_o,
  output logic              res_illegal_o
);
  localparam int unsigned EXT_W = WIDTH - OFF_W;

  logic [WIDTH-1:0] op_a, op_b, seq_pc, tgt_pc;
  logic             taken_c, legal_c;
  logic             valid_q;
  br_res_t          res_d, res_q;

  cbr_operand_latch #(.WIDTH(WIDTH), .BYPASS_EN(BYPASS_EN)) u_latch (
    .clk_i, .rst_ni, .cmp_valid_i, .cmp_a_i, .cmp_b_i,
    .op_a_o(op_a), .op_b_o(op_b)
  );

  cbr_cond_eval #(.WIDTH(WIDTH)) u_eval (
    .clk_i, .rst_ni, .op_a_i(op_a), .op_b_i(op_b),
    .cond_i(br_cond_i), .taken_o(taken_c), .legal_o(legal_c)
  );

  cbr_target_gen #(.WIDTH(WIDTH), .OFF_W(OFF_W), .STEP(2)) u_tgt (
    .pc_i(br_pc_i), .offset_i(br_offset_i),
    .seq_pc_o(seq_pc), .tgt_pc_o(tgt_pc)
  );

  always_comb begin
    res_d.taken   = legal_c && taken_c;
    res_d.illegal = !legal_c;
    if (!legal_c)     res_d.next_pc = br_pc_i;
    else if (taken_c) res_d.next_pc = tgt_pc;
    else              res_d.next_pc = seq_pc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res_q   <= '0;
    end else begin
      valid_q <= br_valid_i;
      if (br_valid_i) res_q <= res_d;
    end
  end

  assign res_valid_o   = valid_q;
  assign res_taken_o   = res_q.taken;
  assign res_illegal_o = res_q.illegal;
  assign res_next_pc_o = res_q.next_pc;

  a_r10_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_i |=> res_valid_o);
  a_r10_valid_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> !res_valid_o);
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !br_valid_i |=> $stable(res_taken_o) && $stable(res_illegal_o) && $stable(res_next_pc_o));
  a_r9_illegal_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (br_valid_i && (br_cond_i > COND_W'(9))) |=>
      res_illegal_o && !res_taken_o && (res_next_pc_o == $past(br_pc_i)));
  a_r8_seq_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_taken_o && !res_illegal_o) |->
      res_next_pc_o == $past(br_pc_i) + WIDTH'(2));
  a_r7_target_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_taken_o) |->
      res_next_pc_o == $past(br_pc_i) + WIDTH'(2) +
        ({{EXT_W{$past(br_offset_i[OFF_W-1])}}, $past(br_offset_i)} << 1));
endmodule

// File: tb/cmp_branch_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_branch_unit_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmp_valid_i = 1'b0;
  logic [31:0] cmp_a_i = '0, cmp_b_i = '0;
  logic        br_valid_i = 1'b0;
  logic [3:0]  br_cond_i = '0;
  logic [9:0]  br_offset_i = '0;
  logic [31:0] br_pc_i = '0;
  logic        res_valid_o, res_taken_o, res_illegal_o;
  logic [31:0] res_next_pc_o;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] ma = '0, mb = '0;

  always #2 clk_i = ~clk_i;

  cmp_branch_unit dut_i (
    .clk_i, .rst_ni, .cmp_valid_i, .cmp_a_i, .cmp_b_i,
    .br_valid_i, .br_cond_i, .br_offset_i, .br_pc_i,
    .res_valid_o, .res_taken_o, .res_next_pc_o, .res_illegal_o
  );

  function automatic logic exp_taken(logic [3:0] c, logic [31:0] a, logic [31:0] b);
    case (c)
      4'd0: return a == b;
      4'd1: return a != b;
      4'd2: return $signed(a) <  $signed(b);
      4'd3: return $signed(a) >  $signed(b);
      4'd6: return $signed(a) >= $signed(b);
      4'd7: return $signed(a) <= $signed(b);
      4'd4: return a <  b;
      4'd5: return a >  b;
      4'd8: return a >= b;
      4'd9: return a <= b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] exp_pc(logic [3:0] c, logic t, logic [9:0] off, logic [31:0] pc);
    logic [31:0] ext;
    ext = {{22{off[9]}}, off};
    if (c > 4'd9) return pc;
    if (t) return pc + 32'd2 + (ext << 1);
    return pc + 32'd2;
  endfunction

  function automatic string req_of(logic [3:0] c);
    if (c > 4'd9) return "R9";
    if (c == 4'd0 || c == 4'd1) return "R4";
    if (c == 4'd4 || c == 4'd5 || c == 4'd8 || c == 4'd9) return "R6";
    return "R5";
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // drive one cycle starting at a negedge, check at the following negedge
  task automatic step(bit cmp, logic [31:0] a, logic [31:0] b,
                      bit br, logic [3:0] c, logic [9:0] off, logic [31:0] pc, string tag);
    logic t;
    logic [31:0] prev_pc;
    logic prev_t, prev_i;
    prev_pc = res_next_pc_o; prev_t = res_taken_o; prev_i = res_illegal_o;
    cmp_valid_i = cmp; cmp_a_i = a; cmp_b_i = b;
    br_valid_i = br; br_cond_i = c; br_offset_i = off; br_pc_i = pc;
    if (cmp) begin ma = a; mb = b; end
    @(negedge clk_i);
    cmp_valid_i = 1'b0; br_valid_i = 1'b0;
    chk("R10", {31'd0, res_valid_o}, {31'd0, br});
    if (br) begin
      t = exp_taken(c, ma, mb);
      chk({req_of(c), tag}, {31'd0, res_taken_o}, {31'd0, t});
      chk((c > 4'd9) ? "R9" : (t ? "R7" : "R8"), res_next_pc_o, exp_pc(c, t, off, pc));
      chk("R9", {31'd0, res_illegal_o}, {31'd0, (c > 4'd9)});
    end else begin
      chk("R11", {prev_i, prev_t, prev_pc[29:0]}, {res_illegal_o, res_taken_o, res_next_pc_o[29:0]});
    end
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk("R1", {29'd0, res_valid_o, res_taken_o, res_illegal_o}, 32'd0);
    chk("R1", res_next_pc_o, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1: latches reset to zero, equal test taken
    step(0, 0, 0, 1, 4'd0, 10'd4, 32'h100, " R1");
    // R2: compare then branch in a later cycle
    step(1, 32'd5, 32'd9, 0, 4'd0, 10'd0, 32'h0, " R2");
    step(0, 0, 0, 0, 4'd0, 10'd0, 32'h0, " R2");
    step(0, 0, 0, 1, 4'd4, 10'h3FF, 32'h2000, " R2");
    // R3: same-cycle compare overrides the stored pair
    step(1, 32'hFFFF_FFFF, 32'd1, 1, 4'd2, 10'h200, 32'h400, " R3");
    step(1, 32'hFFFF_FFFF, 32'd1, 1, 4'd5, 10'h1FF, 32'h400, " R3");
    // R5/R6: sign boundary
    step(1, 32'h8000_0000, 32'h7FFF_FFFF, 1, 4'd3, 10'd1, 32'h10, " R5");
    step(0, 0, 0, 1, 4'd9, 10'd1, 32'h10, " R6");
    step(0, 0, 0, 1, 4'd8, 10'd1, 32'h10, " R6");
    // equal operands for the or-equal codes
    step(1, 32'd77, 32'd77, 1, 4'd6, 10'h3FE, 32'h80, " R5");
    step(0, 0, 0, 1, 4'd7, 10'd0, 32'h80, " R5");
    step(0, 0, 0, 1, 4'd1, 10'd0, 32'h80, " R4");
    // R9: every undefined code
    for (int c = 10; c < 16; c++) step(0, 0, 0, 1, 4'(c), 10'd3, 32'h5000, " R9");
    // R7: offset wrap at PC zero
    step(1, 32'd0, 32'd1, 1, 4'd1, 10'h200, 32'h0, " R7");
    // random
    for (int i = 0; i < 2000; i++) begin
      logic [31:0] a, b;
      a = $urandom;
      b = ($urandom_range(0, 3) == 0) ? a : $urandom;
      if ($urandom_range(0, 3) == 0) a[31] = ~a[31];
      step($urandom_range(0, 1) == 1, a, b, $urandom_range(0, 3) != 0,
           4'($urandom_range(0, 15)), 10'($urandom), $urandom, " rnd");
    end
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule